// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block holds three independent 16-bit down-counters that share one 8-bit register port and one control-word decoder. Software picks a channel and its operating mode with a control word, then loads a 16-bit start value as two byte writes, low byte first. Each channel counts down by one on every cycle where the shared tick enable is high. The tick enable is meant to run near 1.19 MHz, derived from the system clock.

A channel can run in one of three modes. The one-shot mode raises its output level once at terminal count and holds it there. The rate mode reloads by itself and fires periodically. The square mode also reloads by itself, and it toggles its output level at every expiry. Each expiry gives a single-cycle terminal-count pulse, which is meant for use as an interrupt.

The count is read back as two bytes, low then high. A latch command takes a frozen copy of the count, so that both bytes of a read come from the same instant. Control words the block does not support produce an error pulse and leave every channel unchanged.

Top module: `pit_timer`

## Requirements
- R1: A write to address 3 is a control word. Its bits are decoded as follows:
  - bits 7:6 select the channel (0 to 2);
  - bits 5:4 give the access kind, where 0 means latch and 3 means low-then-high programming;
  - bits 3:1 give the mode, where 0 is one-shot, 2 is rate and 3 is square;
  - bit 0 requests BCD counting.

  Addresses 0 to 2 carry the data bytes of channels 0 to 2.
- R2: The following control words are rejected: channel field 3, access field 1 or 2, a BCD request, or a mode other than 0, 2 or 3. A rejected word raises `cfg_err` for exactly the one cycle after the write and changes no channel state.
- R3: Writing a channel's low byte stops that channel and drives its output low, and the next data write to that channel is taken as the high byte. Writing the high byte completes the 16-bit start value and starts counting, subject to R5 and R6.
- R4: A running channel decrements only on clock edges where `tick_en` is high.
- R5: In one-shot mode, a start value of N expires after N ticks. At expiry the output goes high and stays high, and `tc_pulse` is high for the one cycle after the expiring edge. A start value of 0 does not start the channel.
- R6: In rate and square modes, the period is the start value minus 1 ticks. The channel reloads automatically and pulses `tc_pulse` on every expiry. A start value of 0 or 1 leaves the channel idle.
- R7: In square mode the output toggles at every expiry. In rate mode the output stays low.
- R8: Read data alternate between the low byte and the high byte, starting with the low byte. The value returned depends on the channel state:
  - a running one-shot channel returns its remaining ticks;
  - a running periodic channel returns its remaining ticks plus 1;
  - a channel that is idle, stopped or expired returns 0.
- R9: A latch command freezes the selected channel's current count and points the read at the low byte. Further latch commands are ignored until the high byte of the frozen value has been read. That read releases the latch.
- R10: Reset clears all counts, outputs, pulses, latches and errors, and returns both byte pointers of every channel to the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per timer tick |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port; advances the read byte pointer |
| addr | input | 2 | 0 to 2 select a channel's data byte; 3 selects the control word |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current access; 0 when no channel is read |
| tc_pulse | output | 3 | Per-channel terminal-count pulse |
| out_lvl | output | 3 | Per-channel output level |
| cfg_err | output | 1 | One-cycle pulse after a rejected control word |

## Verification
The latch case is the hardest one to reach from the ports. The test has to show that a second latch command is ignored while the first frozen value is still unread, and that the count it returns differs from the live one. To do this, the stimulus loads a channel with ticks disabled and latches it. It then enables ticks, issues another latch, and reads both bytes, so that the live count has clearly moved away from the frozen value. The reference model in the bench tracks every channel cycle by cycle. Because of this, every read, pulse and level is checked, including the rejected control words that must leave a running square wave undisturbed.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Operating mode of one channel; encodings match the mode field values.
    typedef enum logic [1:0] {
        PIT_ONESHOT = 2'd0,
        PIT_RATE    = 2'd2,
        PIT_SQUARE  = 2'd3
    } pit_mode_e;

    // Layout of a control word, most significant field first.
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    localparam logic [1:0] ACC_LATCH = 2'd0;
    localparam logic [1:0] ACC_LOHI  = 2'd3;

endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_data,
    output logic [NUM_CH-1:0] mode_we,
    output logic [NUM_CH-1:0] latch_req,
    output pit_mode_e         mode_val,
    output logic              cfg_err
);

    typedef struct packed {
        logic err;
    } dec_state_t;

    dec_state_t q, d;
    ctl_word_t  cw;
    logic       sel_ok;
    logic       mode_ok;

    always_comb begin
        cw       = ctl_word_t'(ctl_data);
        d        = '0;
        mode_we  = '0;
        latch_req = '0;
        sel_ok   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cw.sel == 2'(i)) sel_ok = 1'b1;
        end
        mode_ok = (cw.mode == 3'd0) || (cw.mode == 3'd2) || (cw.mode == 3'd3);
        case (cw.mode)
            3'd2:    mode_val = PIT_RATE;
            3'd3:    mode_val = PIT_SQUARE;
            default: mode_val = PIT_ONESHOT;
        endcase
        if (ctl_we) begin
            if (!sel_ok) begin
                d.err = 1'b1;
            end else if (cw.acc == ACC_LATCH) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (cw.sel == 2'(i)) latch_req[i] = 1'b1;
                end
            end else if ((cw.acc != ACC_LOHI) || cw.bcd || !mode_ok) begin
                d.err = 1'b1;
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (cw.sel == 2'(i)) mode_we[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cfg_err = q.err;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             mode_we,
    input  pit_mode_e        mode_val,
    input  logic             latch_req,
    input  logic             data_we,
    input  logic             data_rd,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_byte,
    output logic             tc_pulse,
    output logic             out_lvl
);

    localparam int CNT_W = 2 * BUS_W;

    typedef struct packed {
        pit_mode_e        mode;
        logic [CNT_W-1:0] init;
        logic [CNT_W-1:0] remain;
        logic             run;
        logic             out;
        logic             tc;
        logic             wr_hi;
        logic             rd_hi;
        logic             lat_on;
        logic [CNT_W-1:0] lat_val;
    } ch_state_t;

    ch_state_t        q, d;
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] rd_src;
    logic [CNT_W-1:0] new_init;

    // Whether a start value gives a nonzero period in the given mode.
    function automatic logic can_start(pit_mode_e m, logic [CNT_W-1:0] ic);
        if (m == PIT_ONESHOT) return ic != '0;
        return ic > CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] period_of(pit_mode_e m, logic [CNT_W-1:0] ic);
        if (m == PIT_ONESHOT) return ic;
        return ic - 1'b1;
    endfunction

    always_comb begin
        if (!q.run)                    live_cnt = '0;
        else if (q.mode == PIT_ONESHOT) live_cnt = q.remain;
        else                           live_cnt = q.remain + 1'b1;
        rd_src  = q.lat_on ? q.lat_val : live_cnt;
        rd_byte = q.rd_hi ? rd_src[CNT_W-1:BUS_W] : rd_src[BUS_W-1:0];
        new_init = {wr_data, q.init[BUS_W-1:0]};

        d    = q;
        d.tc = 1'b0;

        // Counting.
        if (q.run && tick_en) begin
            if (q.remain == CNT_W'(1)) begin
                d.tc = 1'b1;
                if (q.mode == PIT_ONESHOT) begin
                    d.out    = 1'b1;
                    d.run    = 1'b0;
                    d.remain = '0;
                end else begin
                    if (can_start(q.mode, q.init)) begin
                        d.remain = period_of(q.mode, q.init);
                    end else begin
                        d.run    = 1'b0;
                        d.remain = '0;
                    end
                    if (q.mode == PIT_SQUARE) d.out = ~q.out;
                end
            end else begin
                d.remain = q.remain - 1'b1;
            end
        end

        // Control word effects.
        if (mode_we) d.mode = mode_val;
        if (latch_req && !q.lat_on) begin
            d.lat_on  = 1'b1;
            d.rd_hi   = 1'b0;
            d.lat_val = live_cnt;
        end

        // Read pointer.
        if (data_rd) begin
            if (q.rd_hi) begin
                d.rd_hi  = 1'b0;
                d.lat_on = 1'b0;
            end else begin
                d.rd_hi = 1'b1;
            end
        end

        // Data writes take priority over counting.
        if (data_we) begin
            d.tc = 1'b0;
            if (!q.wr_hi) begin
                d.init[BUS_W-1:0] = wr_data;
                d.run    = 1'b0;
                d.out    = 1'b0;
                d.remain = '0;
                d.wr_hi  = 1'b1;
            end else begin
                d.init  = new_init;
                d.wr_hi = 1'b0;
                if (can_start(q.mode, new_init)) begin
                    d.run    = 1'b1;
                    d.remain = period_of(q.mode, new_init);
                end else begin
                    d.run    = 1'b0;
                    d.remain = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tc_pulse = q.tc;
    assign out_lvl  = q.out;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int BUS_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick_en,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_CH+1)-1:0] addr,
    input  logic [BUS_W-1:0]            wr_data,
    output logic [BUS_W-1:0]            rd_data,
    output logic [NUM_CH-1:0]           tc_pulse,
    output logic [NUM_CH-1:0]           out_lvl,
    output logic                        cfg_err
);

    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    logic [NUM_CH-1:0] mode_we;
    logic [NUM_CH-1:0] latch_req;
    pit_mode_e         mode_val;
    logic [BUS_W-1:0]  ch_rd [NUM_CH];

    pit_ctrl_dec #(.NUM_CH(NUM_CH)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (wr_en && (addr == CTL_ADDR)),
        .ctl_data  (wr_data[7:0]),
        .mode_we   (mode_we),
        .latch_req (latch_req),
        .mode_val  (mode_val),
        .cfg_err   (cfg_err)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_channel #(.BUS_W(BUS_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_en   (tick_en),
            .mode_we   (mode_we[g]),
            .mode_val  (mode_val),
            .latch_req (latch_req[g]),
            .data_we   (wr_en && (addr == ADDR_W'(g))),
            .data_rd   (rd_en && (addr == ADDR_W'(g))),
            .wr_data   (wr_data),
            .rd_byte   (ch_rd[g]),
            .tc_pulse  (tc_pulse[g]),
            .out_lvl   (out_lvl[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_en && (addr == ADDR_W'(i))) rd_data = ch_rd[i];
        end
    end

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
    parameter int NUM_CH = 3,
    parameter int BUS_W  = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick_en,
    input logic                        wr_en,
    input logic [$clog2(NUM_CH+1)-1:0] addr,
    input logic [BUS_W-1:0]            wr_data,
    input logic [NUM_CH-1:0]           tc_pulse,
    input logic [NUM_CH-1:0]           out_lvl,
    input logic                        cfg_err
);

    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // A terminal-count pulse needs a tick on the edge before it.
        assert_tc_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[g] |-> $past(tick_en));

        // The output level moves only at an expiry or after a data write.
        assert_out_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(out_lvl[g]) |-> (tc_pulse[g] || $past(wr_en && (addr == ADDR_W'(g)))));
    end

    // An error pulse must follow a control-word write.
    assert_err_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(wr_en && (addr == CTL_ADDR)));

    // Channel field 3 is always rejected.
    assert_readback_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == CTL_ADDR) && (wr_data[7:6] == 2'd3)) |=> cfg_err);

endmodule

bind pit_timer pit_timer_chk #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .tc_pulse (tc_pulse),
    .out_lvl  (out_lvl),
    .cfg_err  (cfg_err)
);

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/1ps
module pit_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [2:0] tc_pulse;
    logic [2:0] out_lvl;
    logic       cfg_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc_cnt = 0;
    int tick_div = 0;
    int tick_ph = 0;

    // Reference model state.
    int m_mode[3], m_init[3], m_rem[3], m_run[3], m_out[3], m_tc[3];
    int m_wrhi[3], m_rdhi[3], m_lat[3], m_latv[3];
    int m_err;

    always #2.5 clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .tc_pulse(tc_pulse),
        .out_lvl(out_lvl), .cfg_err(cfg_err)
    );

    function automatic int m_live(int i);
        if (m_run[i] == 0) return 0;
        if (m_mode[i] == 0) return m_rem[i];
        return m_rem[i] + 1;
    endfunction

    function automatic int m_ok(int md, int ic);
        if (md == 0) return (ic != 0) ? 1 : 0;
        return (ic > 1) ? 1 : 0;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model update on every edge, from the inputs held across it.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_mode[i] = 0; m_init[i] = 0; m_rem[i] = 0; m_run[i] = 0; m_out[i] = 0;
                m_tc[i] = 0; m_wrhi[i] = 0; m_rdhi[i] = 0; m_lat[i] = 0; m_latv[i] = 0;
            end
            m_err = 0;
        end else begin
            int sel, acc, md, bcd;
            sel = wr_data[7:6]; acc = wr_data[5:4]; md = wr_data[3:1]; bcd = wr_data[0];
            m_err = 0;
            if (wr_en && addr == 3) begin
                if (sel == 3) m_err = 1;
                else if (acc != 0 && (acc != 3 || bcd == 1 || !(md == 0 || md == 2 || md == 3)))
                    m_err = 1;
            end
            for (int i = 0; i < 3; i++) begin
                int live;
                bit wr_here;
                live = m_live(i);
                wr_here = wr_en && addr == i;
                m_tc[i] = 0;
                if (m_run[i] == 1 && tick_en && !wr_here) begin
                    if (m_rem[i] == 1) begin
                        m_tc[i] = 1;
                        if (m_mode[i] == 0) begin
                            m_out[i] = 1; m_run[i] = 0; m_rem[i] = 0;
                        end else begin
                            if (m_ok(m_mode[i], m_init[i]) == 1) m_rem[i] = m_init[i] - 1;
                            else begin m_run[i] = 0; m_rem[i] = 0; end
                            if (m_mode[i] == 3) m_out[i] = 1 - m_out[i];
                        end
                    end else m_rem[i] = m_rem[i] - 1;
                end
                if (wr_en && addr == 3 && m_err == 0 && sel == i) begin
                    if (acc == 0) begin
                        if (m_lat[i] == 0) begin m_lat[i] = 1; m_rdhi[i] = 0; m_latv[i] = live; end
                    end else m_mode[i] = md;
                end
                if (rd_en && addr == i) begin
                    if (m_rdhi[i] == 1) begin m_rdhi[i] = 0; m_lat[i] = 0; end
                    else m_rdhi[i] = 1;
                end
                if (wr_here) begin
                    if (m_wrhi[i] == 0) begin
                        m_init[i] = (m_init[i] & 'hFF00) | wr_data;
                        m_run[i] = 0; m_out[i] = 0; m_rem[i] = 0; m_wrhi[i] = 1;
                    end else begin
                        m_init[i] = (m_init[i] & 'h00FF) | (int'(wr_data) << 8);
                        m_wrhi[i] = 0;
                        if (m_ok(m_mode[i], m_init[i]) == 1) begin
                            m_run[i] = 1;
                            m_rem[i] = (m_mode[i] == 0) ? m_init[i] : m_init[i] - 1;
                        end else begin m_run[i] = 0; m_rem[i] = 0; end
                    end
                end
            end
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 cfg_err", 32'(cfg_err), 32'(m_err));
            for (int i = 0; i < 3; i++) begin
                chk(m_mode[i] == 0 ? "R5 tc_pulse" : "R6 tc_pulse", 32'(tc_pulse[i]), 32'(m_tc[i]));
                chk(m_mode[i] == 3 ? "R7 out_lvl" : "R5 out_lvl", 32'(out_lvl[i]), 32'(m_out[i]));
            end
            if (rd_en && addr != 3) begin
                int src;
                src = (m_lat[addr] == 1) ? m_latv[addr] : m_live(addr);
                chk(m_lat[addr] == 1 ? "R9 rd_data" : "R8 rd_data", 32'(rd_data),
                    32'((m_rdhi[addr] == 1) ? (src >> 8) & 255 : src & 255));
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc_cnt);
            report();
            $finish;
        end
    end

    task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] dat);
        @(posedge clk);
        #1;
        wr_en = w; rd_en = r; addr = a; wr_data = dat;
        tick_en = (tick_div == 0) ? 1'b0 : ((tick_ph % tick_div) == 0);
        tick_ph++;
    endtask

    task automatic set_tick(input int div);
        tick_div = div;
        tick_ph = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic settle();
        cyc(1'b0, 1'b0, 2'd0, 8'd0);
        @(negedge clk);
    endtask

    task automatic rd_pair(input logic [1:0] ch, input int exp, input string tag);
        cyc(1'b0, 1'b1, ch, 8'd0);
        @(negedge clk);
        chk(tag, 32'(rd_data), 32'(exp & 255));
        cyc(1'b0, 1'b1, ch, 8'd0);
        @(negedge clk);
        chk(tag, 32'(rd_data), 32'((exp >> 8) & 255));
    endtask

    task automatic load(input logic [1:0] ch, input logic [7:0] ctl, input int cnt);
        cyc(1'b1, 1'b0, 2'd3, ctl);
        cyc(1'b1, 1'b0, ch, 8'(cnt & 255));
        cyc(1'b1, 1'b0, ch, 8'((cnt >> 8) & 255));
    endtask

    initial begin
        int cnt;
        logic prev;
        set_tick(0);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state visible at the ports.
        chk("R10 tc_pulse", 32'(tc_pulse), 32'd0);
        chk("R10 out_lvl", 32'(out_lvl), 32'd0);
        chk("R10 cfg_err", 32'(cfg_err), 32'd0);
        for (int i = 0; i < 3; i++) rd_pair(2'(i), 0, "R10 idle read");

        // R1 R8: program and read back with ticks off.
        load(2'd0, 8'h30, 5);
        load(2'd1, 8'h74, 'h0104);
        settle();
        rd_pair(2'd0, 5, "R8 one-shot live");
        rd_pair(2'd1, 'h0104, "R8 periodic live plus one");

        // R9: frozen value survives ticking and a second latch.
        cyc(1'b1, 1'b0, 2'd3, 8'h40);
        set_tick(1);
        idle(5);
        cyc(1'b1, 1'b0, 2'd3, 8'h40);
        idle(2);
        rd_pair(2'd1, 'h0104, "R9 latched value");
        cyc(1'b0, 1'b1, 2'd1, 8'd0);
        cyc(1'b0, 1'b1, 2'd1, 8'd0);
        settle();
        chk("R5 one-shot output held", 32'(out_lvl[0]), 32'd1);

        // R6: periodic pulses with period start-1.
        set_tick(0);
        load(2'd1, 8'h74, 4);
        set_tick(1);
        cnt = 0;
        for (int k = 0; k < 30; k++) begin
            idle(1);
            @(negedge clk);
            if (tc_pulse[1]) cnt++;
        end
        chk("R6 pulse count", 32'(cnt), 32'd9);

        // R6: start value 1 in rate mode stays idle; R7 rate output low.
        set_tick(0);
        load(2'd1, 8'h74, 1);
        set_tick(1);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            idle(1);
            @(negedge clk);
            if (tc_pulse[1]) cnt++;
        end
        chk("R6 idle with count one", 32'(cnt), 32'd0);
        chk("R7 rate output low", 32'(out_lvl[1]), 32'd0);
        rd_pair(2'd1, 0, "R6 idle reads zero");

        // R1 R7: square wave on channel 2 toggles.
        load(2'd2, 8'hB6, 3);
        cnt = 0;
        prev = out_lvl[2];
        for (int k = 0; k < 20; k++) begin
            idle(1);
            @(negedge clk);
            if (out_lvl[2] !== prev) cnt++;
            prev = out_lvl[2];
        end
        chk("R1 R7 square toggles", 32'(cnt >= 8), 32'd1);

        // R2: rejected control words.
        begin
            logic [7:0] bad [6] = '{8'hC0, 8'h31, 8'h12, 8'h22, 8'hB2, 8'h38};
            for (int k = 0; k < 6; k++) begin
                cyc(1'b1, 1'b0, 2'd3, bad[k]);
                settle();
                chk("R2 error pulse", 32'(cfg_err), 32'd1);
                idle(3);
            end
        end

        // R3: low byte alone stops the channel.
        cyc(1'b1, 1'b0, 2'd2, 8'h05);
        settle();
        chk("R3 output low after low byte", 32'(out_lvl[2]), 32'd0);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            idle(1);
            @(negedge clk);
            if (tc_pulse[2]) cnt++;
        end
        chk("R3 stopped no pulses", 32'(cnt), 32'd0);
        rd_pair(2'd2, 0, "R3 stopped reads zero");
        cyc(1'b1, 1'b0, 2'd2, 8'h00);
        idle(12);

        // R4: ticks every third cycle.
        set_tick(0);
        load(2'd0, 8'h30, 10);
        set_tick(3);
        idle(9);
        set_tick(0);
        settle();
        rd_pair(2'd0, 7, "R4 three ticks");

        // R5: start value 0 does not start a one-shot.
        load(2'd0, 8'h30, 0);
        set_tick(1);
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            idle(1);
            @(negedge clk);
            if (tc_pulse[0]) cnt++;
        end
        chk("R5 zero count idle", 32'(cnt), 32'd0);
        chk("R5 zero count output", 32'(out_lvl[0]), 32'd0);

        set_tick(0);
        idle(2);
        report();
        $finish;
    end

endmodule